// File: doc/BRIEF.md
# Serial port status flag register

This block holds the eight status bits of a serial port: five event flags (transmit holding buffer empty, receive buffer full, overrun, framing error, parity error), a transmit-complete bit, the multiprocessor bit taken from the last received frame, and a multiprocessor bit that software sets for the next transmitted frame. The transmitter and receiver report events on single-cycle pulse inputs. The CPU reads and writes the register over an 8-bit bus. The read value is always visible on `rdata`.

The five event flags use a read-then-clear protocol. The CPU can only clear such a flag by writing 0 to it, and the write works only if an earlier CPU read saw that flag at 1. Writing 1 never sets a flag. A hardware set event that arrives between the read and the write cancels the pending clear, so a new event cannot be lost. A hardware set always wins over a clear in the same cycle. The interface uses plain strobes with no back-pressure: every CPU access and every event pulse is taken in the cycle it is asserted.

Top module: `ssr_status_reg`

## Requirements
- R1: `rdata` shows, from bit 7 down to bit 0: transmit-empty, receive-full, overrun, framing error, parity error, transmit-complete, received multiprocessor bit, transmit multiprocessor bit.
- R2: Asynchronous reset (`rst_n` low) and a synchronous `lp_init` pulse both load 0x84 and cancel every pending clear.
- R3: Writing 1 to any of bits 7..3 never sets that flag.
- R4: Writing 0 to bits 7..3 clears a flag only if a CPU read in an earlier cycle saw that flag at 1. Otherwise the flag keeps its value.
- R5: A hardware set event for a flag after the qualifying read cancels the pending clear. A later 0-write then leaves the flag at 1.
- R6: When a hardware set and a CPU clear (or DMA clear) of the same flag fall in one cycle, the flag ends at 1.
- R7: Transmit-empty is set by `tx_load` and held at 1 while `tx_en` is 0. A `dma_tx_wr` pulse clears it unless a set source is active in that cycle.
- R8: Transmit-complete (bit 2) ignores CPU writes. It is set by `tend_set` and cleared by `tend_clr`, and set wins.
- R9: The received multiprocessor bit (bit 1) ignores CPU writes. It takes `mpb_in` when `mpb_load` is 1.
- R10: Bit 0 is plain read/write: every CPU write loads `cpu_wdata[0]`.
- R11: A CPU write with 1 in a flag's bit leaves that flag and its pending clear unchanged.
- R12: A read and a 0-write in the same cycle do not clear a flag that was not already armed. That read arms the flag for a later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_init | input | 1 | Synchronous reinitialisation on low-power entry |
| cpu_rd | input | 1 | CPU read strobe; `rdata` is the value read |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| tx_en | input | 1 | Transmitter enable |
| tx_load | input | 1 | Holding buffer moved to transmit shifter |
| dma_tx_wr | input | 1 | DMA write to the transmit holding buffer |
| rx_full_set | input | 1 | Received byte available |
| ovr_set | input | 1 | Overrun detected |
| frm_set | input | 1 | Framing error detected |
| par_set | input | 1 | Parity error detected |
| tend_set | input | 1 | Transmission complete |
| tend_clr | input | 1 | Transmission restarted |
| mpb_load | input | 1 | Load received multiprocessor bit |
| mpb_in | input | 1 | Received multiprocessor bit value |
| rdata | output | 8 | Register read value |

## Verification
Every input takes effect at the rising edge where it is sampled, and `rdata` shows the result straight from the register flops, so each result is due exactly one edge after its stimulus. The bench drives inputs on falling edges and compares `rdata` with a behavioural model on the next falling edge, which is one full edge after the update. The directed checks follow the same one-edge rule for multi-step sequences: read, then a set event, then a write, each on its own edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int SSR_W     = 8;
  localparam int N_CLR     = 5;   // event flags occupy bits 7..3
  localparam int CLR_LSB   = 3;
  localparam int BIT_TXE   = 7;
  localparam int BIT_TEND  = 2;
  localparam int BIT_MPBR  = 1;
  localparam int BIT_MPBT  = 0;
  localparam logic [SSR_W-1:0] SSR_INIT = 8'h84;
endpackage

// File: rtl/ssr_clr_flag.sv
// Event flag with read-then-clear protection.
module ssr_clr_flag #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o  <= INIT;
      armed_q <= 1'b0;
    end else if (init_i) begin
      flag_o  <= INIT;
      armed_q <= 1'b0;
    end else if (set_i) begin
      // a new event always wins and cancels a pending clear
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (hw_clr_i) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr_i && !wbit_i && armed_q) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && flag_o) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ssr_hw_bit.sv
// Bit owned by hardware only; set has priority over clear.
module ssr_hw_bit #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= INIT;
    else if (init_i)  q_o <= INIT;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
  end
endmodule

// File: rtl/ssr_status_reg.sv
module ssr_status_reg
  import ssr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_init,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [SSR_W-1:0] cpu_wdata,
  input  logic             tx_en,
  input  logic             tx_load,
  input  logic             dma_tx_wr,
  input  logic             rx_full_set,
  input  logic             ovr_set,
  input  logic             frm_set,
  input  logic             par_set,
  input  logic             tend_set,
  input  logic             tend_clr,
  input  logic             mpb_load,
  input  logic             mpb_in,
  output logic [SSR_W-1:0] rdata
);
  logic [N_CLR-1:0] set_ev;
  logic [N_CLR-1:0] hw_clr;
  logic [N_CLR-1:0] clr_q;
  logic             tend_q;
  logic             mpbr_q;
  logic             mpbt_q;

  // index 4..0 maps to register bits 7..3
  always_comb begin
    set_ev = {(!tx_en || tx_load), rx_full_set, ovr_set, frm_set, par_set};
    hw_clr = '0;
    hw_clr[BIT_TXE-CLR_LSB] = dma_tx_wr;
  end

  for (genvar g = 0; g < N_CLR; g++) begin : g_flag
    ssr_clr_flag #(.INIT(SSR_INIT[CLR_LSB+g])) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_i   (lp_init),
      .set_i    (set_ev[g]),
      .hw_clr_i (hw_clr[g]),
      .rd_i     (cpu_rd),
      .wr_i     (cpu_wr),
      .wbit_i   (cpu_wdata[CLR_LSB+g]),
      .flag_o   (clr_q[g])
    );
  end

  ssr_hw_bit #(.INIT(SSR_INIT[BIT_TEND])) u_tend (
    .clk(clk), .rst_n(rst_n), .init_i(lp_init),
    .set_i(tend_set), .clr_i(tend_clr), .q_o(tend_q)
  );

  ssr_hw_bit #(.INIT(SSR_INIT[BIT_MPBR])) u_mpbr (
    .clk(clk), .rst_n(rst_n), .init_i(lp_init),
    .set_i(mpb_load && mpb_in), .clr_i(mpb_load && !mpb_in), .q_o(mpbr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mpbt_q <= SSR_INIT[BIT_MPBT];
    else if (lp_init) mpbt_q <= SSR_INIT[BIT_MPBT];
    else if (cpu_wr)  mpbt_q <= cpu_wdata[BIT_MPBT];
  end

  assign rdata = {clr_q, tend_q, mpbr_q, mpbt_q};
endmodule

// File: rtl/ssr_status_chk.sv
module ssr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_init,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic       tx_en,
  input logic       tx_load,
  input logic       dma_tx_wr,
  input logic       rx_full_set,
  input logic       tend_set,
  input logic       tend_clr,
  input logic       mpb_load,
  input logic       mpb_in,
  input logic [7:0] rdata
);
  p_init_val_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lp_init |=> rdata == 8'h84);
  p_no_write_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdata[6] && !rx_full_set) |=> !rdata[6]);
  p_clear_needs_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[5] && !(cpu_wr && !cpu_wdata[5]) && !lp_init) |=> rdata[5]);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_set && !lp_init) |=> rdata[6]);
  p_txe_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || tx_load) |=> rdata[7]);
  p_dma_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_wr && tx_en && !tx_load && !lp_init) |=> !rdata[7]);
  p_tend_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tend_set && !tend_clr && !lp_init) |=> $stable(rdata[2]));
  p_mpb_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mpb_load && !lp_init) |=> rdata[1] == $past(mpb_in));
  p_mpb_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !lp_init) |=> rdata[0] == $past(cpu_wdata[0]));
endmodule

bind ssr_status_reg ssr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lp_init(lp_init), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .tx_en(tx_en), .tx_load(tx_load),
  .dma_tx_wr(dma_tx_wr), .rx_full_set(rx_full_set), .tend_set(tend_set),
  .tend_clr(tend_clr), .mpb_load(mpb_load), .mpb_in(mpb_in), .rdata(rdata)
);

// File: tb/ssr_status_reg_bench.sv
`timescale 1ns/1ps
module ssr_status_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_init = 0, cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 8'h00;
  logic tx_en = 0, tx_load = 0, dma_tx_wr = 0;
  logic rx_full_set = 0, ovr_set = 0, frm_set = 0, par_set = 0;
  logic tend_set = 0, tend_clr = 0, mpb_load = 0, mpb_in = 0;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_v;
  logic [7:0] exp_arm;

  always #10 clk = ~clk;   // 50 MHz

  ssr_status_reg u_ssr_status_reg (
    .clk(clk), .rst_n(rst_n), .lp_init(lp_init), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .tx_en(tx_en), .tx_load(tx_load),
    .dma_tx_wr(dma_tx_wr), .rx_full_set(rx_full_set), .ovr_set(ovr_set),
    .frm_set(frm_set), .par_set(par_set), .tend_set(tend_set),
    .tend_clr(tend_clr), .mpb_load(mpb_load), .mpb_in(mpb_in), .rdata(rdata)
  );

  // Behavioural reference model, updated at every rising edge
  always @(posedge clk) begin
    logic [7:0] nv;
    logic [7:0] na;
    if (!rst_n || lp_init) begin
      nv = 8'h84; na = 8'h00;
    end else begin
      nv = exp_v; na = exp_arm;
      for (int b = 3; b < 8; b++) begin
        bit s;
        bit hc;
        case (b)
          7: s = !tx_en || tx_load;
          6: s = rx_full_set;
          5: s = ovr_set;
          4: s = frm_set;
          default: s = par_set;
        endcase
        hc = (b == 7) && dma_tx_wr;
        if (s) begin nv[b] = 1; na[b] = 0; end
        else if (hc) begin nv[b] = 0; na[b] = 0; end
        else if (cpu_wr && !cpu_wdata[b] && exp_arm[b]) begin nv[b] = 0; na[b] = 0; end
        else if (cpu_rd && exp_v[b]) na[b] = 1;
      end
      if (tend_set) nv[2] = 1; else if (tend_clr) nv[2] = 0;
      if (mpb_load) nv[1] = mpb_in;
      if (cpu_wr) nv[0] = cpu_wdata[0];
    end
    exp_v <= nv;
    exp_arm <= na;
  end

  // compare against the model on every falling edge (R1 layout)
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (rdata !== exp_v) begin
        bad++;
        $display("FAIL R1 model compare: actual=%h expected=%h", rdata, exp_v);
      end
    end
  end

  task automatic chk(input logic [7:0] e, input string tag);
    total++;
    if (rdata !== e) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, rdata, e);
    end
  endtask

  // one rising edge with the current drive, then drop all pulses
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    lp_init = 0; cpu_rd = 0; cpu_wr = 0; tx_load = 0; dma_tx_wr = 0;
    rx_full_set = 0; ovr_set = 0; frm_set = 0; par_set = 0;
    tend_set = 0; tend_clr = 0; mpb_load = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1; cpu_wdata = d; tick();
  endtask

  task automatic rd();
    cpu_rd = 1; tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(8'h84, "R2 reset value");
    tx_en = 1; tick();
    chk(8'h84, "R7 enable keeps empty");
    wr(8'h00);
    chk(8'h84, "R4 clear without read");
    wr(8'hFF);
    chk(8'h85, "R3 R8 R10 write ones");
    rd(); wr(8'h7F);
    chk(8'h05, "R4 R11 read then zero-write");
    tx_load = 1; tick();
    chk(8'h85, "R7 load sets empty");
    rx_full_set = 1; ovr_set = 1; tick();
    chk(8'hE5, "R1 event flags");
    rd(); rx_full_set = 1; tick(); wr(8'h01);
    chk(8'h45, "R5 set between read and write");
    rd(); wr(8'hFF); wr(8'h00);
    chk(8'h04, "R11 one-write keeps arm");
    frm_set = 1; tick(); rd();
    frm_set = 1; cpu_wr = 1; cpu_wdata = 8'h00; tick();
    chk(8'h14, "R6 set wins over clear");
    wr(8'h00);
    chk(8'h14, "R5 disarmed by set");
    cpu_rd = 1; cpu_wr = 1; cpu_wdata = 8'h00; tick();
    chk(8'h14, "R12 same-cycle read and write");
    wr(8'h00);
    chk(8'h04, "R12 armed by same-cycle read");
    tx_load = 1; tick();
    dma_tx_wr = 1; tick();
    chk(8'h04, "R7 DMA clears empty");
    tx_en = 0; dma_tx_wr = 1; tick();
    chk(8'h84, "R7 R6 disabled wins over DMA");
    rd(); wr(8'h00);
    chk(8'h84, "R7 held while disabled");
    tx_en = 1; tend_clr = 1; tick();
    chk(8'h80, "R8 hardware clear");
    tend_set = 1; tend_clr = 1; tick();
    chk(8'h84, "R8 set wins");
    rd(); wr(8'h00);
    chk(8'h04, "R8 write ignored");
    mpb_load = 1; mpb_in = 1; tick();
    chk(8'h06, "R9 load one");
    wr(8'h00);
    chk(8'h06, "R9 write ignored");
    mpb_load = 1; mpb_in = 0; tick();
    chk(8'h04, "R9 load zero");
    par_set = 1; tick(); rd(); wr(8'hF7);
    chk(8'h05, "R4 parity clear");
    lp_init = 1; tick();
    chk(8'h84, "R2 low-power init");
    for (int n = 0; n < 3000; n++) begin
      lp_init = ($urandom_range(0, 99) == 0);
      cpu_rd = $urandom_range(0, 2) == 0;
      cpu_wr = $urandom_range(0, 2) == 0;
      cpu_wdata = 8'($urandom);
      tx_en = $urandom_range(0, 7) != 0;
      tx_load = $urandom_range(0, 7) == 0;
      dma_tx_wr = $urandom_range(0, 5) == 0;
      rx_full_set = $urandom_range(0, 7) == 0;
      ovr_set = $urandom_range(0, 7) == 0;
      frm_set = $urandom_range(0, 7) == 0;
      par_set = $urandom_range(0, 7) == 0;
      tend_set = $urandom_range(0, 7) == 0;
      tend_clr = $urandom_range(0, 7) == 0;
      mpb_load = $urandom_range(0, 5) == 0;
      mpb_in = 1'($urandom);
      tick();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule